// File: doc/BRIEF.md
# Circular Acquisition Sample Buffer

This block sits between a sample producer, such as a converter sequencer, and a host that drains the samples. The producer presents one word per cycle on a valid strobe. Each accepted word is written at the front index, and the front index then moves on by one. The host reads samples straight out of the ring through a word-addressed port. When it has used them, it writes its new read position into the rear index register. The ring depth is a parameter that need not be a power of two, so both indices wrap by comparison and reset to zero.

The number of unread words is the front index minus the rear index, plus the depth when that difference is negative. A level flag reports when this count reaches a host-programmed threshold. A sample that arrives when only one free slot remains is dropped, and a sticky overrun flag is set. Six further sticky flags record events reported by neighbouring logic.

An eight-bit enable mask gates the flag byte onto a single interrupt line. The host clears sticky flags by writing ones to them.

Top module: `acq_ring`

## Requirements
- R1: After reset the front index, rear index and occupancy read 0, the flag byte and the mask read 0, the threshold reads DEPTH/2 (1001 by default), and irq is low.
- R2: A sample presented with smp_valid while the ring is not full is stored at the current front index, and the front index increases by one. A host read at word address A < DEPTH returns the word stored at A on host_rdata in the cycle after the address is presented.
- R3: When the front index is DEPTH-1 and a sample is accepted, the front index becomes 0.
- R4: The occupancy register reads front − rear when front ≥ rear, and front − rear + DEPTH otherwise.
- R5: A sample presented while occupancy equals DEPTH-1 is dropped. The front index and the stored words stay unchanged, and flag bit 1 (overrun) is set.
- R6: Flag bit 0 is 1 exactly when occupancy ≥ threshold. It follows producer writes, rear writes and threshold writes. Writing 1 to bit 0 of the flag register has no effect on it.
- R7: A host write to the rear register with a value below DEPTH loads the rear index. A value of DEPTH or more is ignored.
- R8: Flag bits 1 to 7 are sticky and are cleared by writing 1 to their position. Bit 2 is set by hw_err_in, and bits 3 to 7 are set by aux_evt[0] to aux_evt[4]. A set and a clear of the same bit in the same cycle leaves the bit set.
- R9: irq is high exactly when some flag bit and its mask bit are both 1. A zero mask keeps irq low.
- R10: Registers sit at word addresses 0xFF0 + offset: 0 front (read only), 1 rear, 2 occupancy (read only), 3 threshold, 4 mask (bits 7:0), 5 flags (write 1 to clear). Any other address at or above 0xFF0, and any address from DEPTH up to 0xFEF, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Producer sample strobe |
| smp_data | input | 16 | Producer sample word |
| hw_err_in | input | 1 | Converter hardware error event (flag bit 2) |
| aux_evt | input | 5 | Neighbour events for flag bits 3 to 7 |
| host_addr | input | 12 | Host word address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| irq | output | 1 | Masked interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- both indices stay inside the ring and occupancy never exceeds DEPTH-1;
- the front index steps by one or wraps to zero on each accepted sample;
- a dropped sample leaves the front index still and raises the overrun flag;
- the full flag always matches the comparison of occupancy against the threshold;
- a zero mask keeps irq low.

Other behaviours can only be shown by the bench's scenarios:
- the stored data read back at particular addresses;
- the negative-difference occupancy case after a wrap;
- rejection of out-of-range rear writes;
- the write-one-to-clear behaviour and set-over-clear priority;
- the register map and the reset values.

// File: rtl/acq_ring_pkg.sv
package acq_ring_pkg;

  localparam int unsigned NFLAG     = 8;
  localparam int unsigned FLG_FULL  = 0;
  localparam int unsigned FLG_OVR   = 1;
  localparam int unsigned FLG_HWERR = 2;
  localparam int unsigned FLG_AUX   = 3;
  localparam int unsigned NAUX      = NFLAG - FLG_AUX;

  // Register offsets from the top of the host address space
  typedef enum logic [3:0] {
    RG_FRONT = 4'd0,
    RG_REAR  = 4'd1,
    RG_OCC   = 4'd2,
    RG_THR   = 4'd3,
    RG_MASK  = 4'd4,
    RG_FLAGS = 4'd5
  } reg_sel_e;

  // Next ring position: compare-and-reset because depth is arbitrary
  function automatic int unsigned ring_step(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Unread words between rear and front
  function automatic int unsigned ring_fill(int unsigned f, int unsigned r,
                                            int unsigned depth);
    return (f >= r) ? (f - r) : (f + depth - r);
  endfunction

endpackage

// File: rtl/acq_ring_index.sv
module acq_ring_index #(
  parameter int DEPTH = 2003,
  parameter int IW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          rear_ld,
  input  logic [IW-1:0] rear_val,
  output logic [IW-1:0] front_q,
  output logic [IW-1:0] rear_q,
  output logic [IW-1:0] front_nxt,
  output logic [IW-1:0] occ,
  output logic [IW-1:0] occ_nxt,
  output logic          accept,
  output logic          drop
);
  import acq_ring_pkg::*;

  localparam logic [IW-1:0] LAST_FILL = IW'(DEPTH - 1);

  logic          ring_full;
  logic [IW-1:0] rear_nxt;

  always_comb begin
    occ       = IW'(ring_fill(32'(front_q), 32'(rear_q), DEPTH));
    ring_full = (occ == LAST_FILL);
    accept    = push && !ring_full;
    drop      = push && ring_full;
    front_nxt = accept ? IW'(ring_step(32'(front_q), DEPTH)) : front_q;
    rear_nxt  = rear_ld ? rear_val : rear_q;
    occ_nxt   = IW'(ring_fill(32'(front_nxt), 32'(rear_nxt), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_q <= '0;
      rear_q  <= '0;
    end else begin
      front_q <= front_nxt;
      rear_q  <= rear_nxt;
    end
  end

endmodule

// File: rtl/acq_ring_store.sv
module acq_ring_store #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int IW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (raddr < IW'(DEPTH)) rdata <= mem[raddr];
    else                    rdata <= '0;
  end

endmodule

// File: rtl/acq_ring_flags.sv
module acq_ring_flags
  import acq_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_lvl,
  input  logic             ovr_evt,
  input  logic             hw_evt,
  input  logic [NAUX-1:0]  aux_evt,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [NFLAG-1:0] mask_wdata,
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] mask_q,
  output logic             irq
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] flags_nxt;

  assign set_v = {aux_evt, hw_evt, ovr_evt, 1'b0};

  always_comb begin
    for (int b = 0; b < NFLAG; b++) begin
      if (b == FLG_FULL)           flags_nxt[b] = full_lvl;
      else if (set_v[b])           flags_nxt[b] = 1'b1;
      else if (clr_we && clr_bits[b]) flags_nxt[b] = 1'b0;
      else                         flags_nxt[b] = flags_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flags_nxt;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign irq = |(flags_q & mask_q);

endmodule

// File: rtl/acq_ring.sv
module acq_ring
  import acq_ring_pkg::*;
#(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [DW-1:0]   smp_data,
  input  logic            hw_err_in,
  input  logic [NAUX-1:0] aux_evt,
  input  logic [AW-1:0]   host_addr,
  input  logic            host_we,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            irq
);
  localparam int IW        = $clog2(DEPTH);
  localparam int REG_BASE  = (1 << AW) - 16;
  localparam int THR_RESET = DEPTH / 2;

  // named internal events
  logic [IW-1:0]    front_q, rear_q, front_nxt, occ, occ_nxt, thr_q, thr_nxt;
  logic             accept, drop, full_lvl;
  logic [NFLAG-1:0] flags_q, mask_q;

  // host decode
  logic       in_regs, in_mem;
  reg_sel_e   roff;
  logic       rear_ld, thr_we, mask_we, clr_we;

  always_comb begin
    in_regs = (host_addr >= AW'(REG_BASE));
    in_mem  = (host_addr <  AW'(DEPTH));
    roff    = reg_sel_e'(host_addr[3:0]);
    rear_ld = host_we && in_regs && (roff == RG_REAR) && (host_wdata < DW'(DEPTH));
    thr_we  = host_we && in_regs && (roff == RG_THR);
    mask_we = host_we && in_regs && (roff == RG_MASK);
    clr_we  = host_we && in_regs && (roff == RG_FLAGS);
  end

  acq_ring_index #(.DEPTH(DEPTH), .IW(IW)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (smp_valid),
    .rear_ld  (rear_ld),
    .rear_val (host_wdata[IW-1:0]),
    .front_q  (front_q),
    .rear_q   (rear_q),
    .front_nxt(front_nxt),
    .occ      (occ),
    .occ_nxt  (occ_nxt),
    .accept   (accept),
    .drop     (drop)
  );

  logic [DW-1:0] mem_rdata;

  acq_ring_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_mem (
    .clk  (clk),
    .we   (accept),
    .waddr(front_q),
    .wdata(smp_data),
    .raddr(host_addr[IW-1:0]),
    .rdata(mem_rdata)
  );

  // threshold register
  assign thr_nxt  = thr_we ? host_wdata[IW-1:0] : thr_q;
  assign full_lvl = (occ_nxt >= thr_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= IW'(THR_RESET);
    else        thr_q <= thr_nxt;
  end

  acq_ring_flags u_flg (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_lvl  (full_lvl),
    .ovr_evt   (drop),
    .hw_evt    (hw_err_in),
    .aux_evt   (aux_evt),
    .clr_we    (clr_we),
    .clr_bits  (host_wdata[NFLAG-1:0]),
    .mask_we   (mask_we),
    .mask_wdata(host_wdata[NFLAG-1:0]),
    .flags_q   (flags_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  // registered host read path
  logic [DW-1:0] reg_rd, reg_rd_q;
  logic          sel_mem_q;

  always_comb begin
    reg_rd = '0;
    if (in_regs) begin
      case (roff)
        RG_FRONT: reg_rd = DW'(front_q);
        RG_REAR:  reg_rd = DW'(rear_q);
        RG_OCC:   reg_rd = DW'(occ);
        RG_THR:   reg_rd = DW'(thr_q);
        RG_MASK:  reg_rd = DW'(mask_q);
        RG_FLAGS: reg_rd = DW'(flags_q);
        default:  reg_rd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_q  <= '0;
      sel_mem_q <= 1'b0;
    end else begin
      reg_rd_q  <= reg_rd;
      sel_mem_q <= in_mem;
    end
  end

  assign host_rdata = sel_mem_q ? mem_rdata : reg_rd_q;

endmodule

// File: rtl/acq_ring_chk.sv
module acq_ring_chk #(
  parameter int DEPTH = 2003,
  parameter int IW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] front_q,
  input logic [IW-1:0] rear_q,
  input logic [IW-1:0] occ,
  input logic [IW-1:0] thr_q,
  input logic [7:0]    flags_q,
  input logic [7:0]    mask_q,
  input logic          accept,
  input logic          drop,
  input logic          irq
);
  localparam logic [IW-1:0] LASTI = IW'(DEPTH - 1);

  a_r2_front_range: assert property (@(posedge clk) disable iff (!rst_n)
    front_q <= LASTI);

  a_r7_rear_range: assert property (@(posedge clk) disable iff (!rst_n)
    rear_q <= LASTI);

  a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= LASTI);

  a_r2_front_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && front_q != LASTI) |=> (front_q == $past(front_q) + 1'b1));

  a_r3_front_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && front_q == LASTI) |=> (front_q == '0));

  a_r5_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ($stable(front_q) && flags_q[1]));

  a_r6_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[0] == (occ >= thr_q));

  a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq);

endmodule

bind acq_ring acq_ring_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .front_q(front_q),
  .rear_q (rear_q),
  .occ    (occ),
  .thr_q  (thr_q),
  .flags_q(flags_q),
  .mask_q (mask_q),
  .accept (accept),
  .drop   (drop),
  .irq    (irq)
);

// File: tb/sim_acq_ring.sv
`timescale 1ns/1ps
module sim_acq_ring;

  localparam int DEPTH = 2003;
  localparam logic [11:0] A_FRONT = 12'hFF0, A_REAR = 12'hFF1, A_OCC = 12'hFF2,
                          A_THR = 12'hFF3, A_MASK = 12'hFF4, A_FLAGS = 12'hFF5;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PUSH = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  // Table walk: data is write value, push count, or expected value
  localparam vec_t VT [19] = '{
    '{OP_WR,   A_THR,   16'd4,    4'd6},   // R6 threshold 4
    '{OP_PUSH, 12'd0,   16'd3,    4'd2},
    '{OP_RD,   A_OCC,   16'd3,    4'd4},   // R4
    '{OP_RD,   A_FLAGS, 16'h00,   4'd6},   // R6 below threshold
    '{OP_PUSH, 12'd0,   16'd1,    4'd2},
    '{OP_RD,   A_FLAGS, 16'h01,   4'd6},   // R6 at threshold
    '{OP_RD,   12'd2,   16'h5002, 4'd2},   // R2 stored word
    '{OP_RD,   A_FRONT, 16'd4,    4'd2},   // R2 front advanced
    '{OP_WR,   A_MASK,  16'h01,   4'd9},
    '{OP_IRQ,  12'd0,   16'd1,    4'd9},   // R9
    '{OP_WR,   A_REAR,  16'd2,    4'd7},
    '{OP_RD,   A_OCC,   16'd2,    4'd7},   // R7 rear loaded
    '{OP_RD,   A_FLAGS, 16'h00,   4'd6},   // R6 cleared by rear write
    '{OP_IRQ,  12'd0,   16'd0,    4'd9},   // R9
    '{OP_WR,   A_REAR,  16'd3000, 4'd7},
    '{OP_RD,   A_REAR,  16'd2,    4'd7},   // R7 out-of-range ignored
    '{OP_RD,   12'hFF8, 16'h0000, 4'd10},  // R10 unmapped
    '{OP_WR,   A_MASK,  16'h00,   4'd9},
    '{OP_RD,   A_FLAGS, 16'h00,   4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        hw_err_in = 1'b0;
  logic [4:0]  aux_evt = '0;
  logic [11:0] host_addr = '0;
  logic        host_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int pcount = 0;
  logic [15:0] last_pushed = '0;

  always #10 clk = ~clk;

  acq_ring u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .hw_err_in(hw_err_in), .aux_evt(aux_evt), .host_addr(host_addr),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a;
    @(posedge clk);
    #1 v = host_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [15:0] exp);
    logic [15:0] v;
    host_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic irq_check(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {15'b0, irq}, {15'b0, exp});
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = 16'h5000 + 16'(pcount);
      last_pushed = smp_data;
      pcount++;
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic events(input logic hw, input logic [4:0] aux, input logic clr,
                        input logic [7:0] clr_bits);
    @(negedge clk);
    hw_err_in = hw; aux_evt = aux;
    host_addr = A_FLAGS; host_wdata = {8'h00, clr_bits}; host_we = clr;
    @(negedge clk);
    hw_err_in = 1'b0; aux_evt = '0; host_we = 1'b0;
  endtask

  task automatic reset_check();
    rd_check("R1 front", A_FRONT, 16'd0);
    rd_check("R1 rear",  A_REAR,  16'd0);
    rd_check("R1 occ",   A_OCC,   16'd0);
    rd_check("R1 thr",   A_THR,   16'd1001);
    rd_check("R1 mask",  A_MASK,  16'd0);
    rd_check("R1 flags", A_FLAGS, 16'd0);
    irq_check("R1 irq", 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] saved_2002;
    logic [15:0] saved_2001;
    int front_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reset_check();

    // vector table
    for (int k = 0; k < 19; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VT[k].req, k);
      case (VT[k].op)
        OP_WR:   host_write(VT[k].addr, VT[k].data);
        OP_RD:   rd_check(tag, VT[k].addr, VT[k].data);
        OP_PUSH: push_n(int'(VT[k].data));
        default: irq_check(tag, VT[k].data[0]);
      endcase
    end

    // R3 wrap: consume as fast as produced until front reaches DEPTH-1
    front_m = 4;
    host_write(A_REAR, 16'(front_m));
    while (front_m != DEPTH - 1) begin
      push_n(1);
      front_m++;
      host_write(A_REAR, 16'(front_m));
    end
    push_n(1);
    saved_2002 = last_pushed;
    rd_check("R3 front wrapped", A_FRONT, 16'd0);
    rd_check("R2 word at last slot", 12'd2002, saved_2002);
    rd_check("R4 negative difference", A_OCC, 16'd1);

    // R5 overrun and R6 boundary
    host_write(A_REAR, 16'd0);
    host_write(A_THR, 16'd1001);
    push_n(1000);
    rd_check("R6 one below threshold", A_FLAGS, 16'h00);
    push_n(1);
    rd_check("R6 at threshold", A_FLAGS, 16'h01);
    push_n(1001);
    saved_2001 = last_pushed;
    rd_check("R4 ring nearly full", A_OCC, 16'd2002);
    push_n(1);
    rd_check("R5 front held", A_FRONT, 16'd2002);
    rd_check("R5 overrun flag", A_FLAGS, 16'h03);
    rd_check("R5 slot untouched", 12'd2002, saved_2002);
    rd_check("R2 last accepted", 12'd2001, saved_2001);

    // R9 / R8 masking and clear
    host_write(A_MASK, 16'h02);
    irq_check("R9 overrun enabled", 1'b1);
    host_write(A_FLAGS, 16'h02);
    rd_check("R8 w1c overrun", A_FLAGS, 16'h01);
    irq_check("R9 cleared source", 1'b0);
    host_write(A_MASK, 16'hFF);
    irq_check("R9 full enabled", 1'b1);
    host_write(A_MASK, 16'h00);
    irq_check("R9 zero mask", 1'b0);

    // R8 event sources and priority
    events(1'b1, 5'b10101, 1'b0, 8'h00);
    rd_check("R8 event bits", A_FLAGS, 16'hAD);
    events(1'b1, 5'b00000, 1'b1, 8'h04);
    rd_check("R8 set beats clear", A_FLAGS, 16'hAD);
    host_write(A_FLAGS, 16'h00FE);
    rd_check("R8 clear all sticky", A_FLAGS, 16'h01);
    host_write(A_FLAGS, 16'h0001);
    rd_check("R6 level bit ignores w1c", A_FLAGS, 16'h01);
    host_write(A_REAR, 16'd2001);
    rd_check("R7 rear load", A_OCC, 16'd1);
    rd_check("R6 drops with rear", A_FLAGS, 16'h00);
    rd_check("R10 hole below regs", 12'hF00, 16'h0000);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reset_check();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule